// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block moves a run of bytes between a local byte buffer and system memory. It follows a table of 8-byte descriptors that sits in memory. It has one memory port with a valid/ready request channel and a single-beat read response. It uses that port both to fetch descriptors and to move data. Each piece of data it moves is bounded by three limits: the bytes still owed to the buffer, the bytes still left in the current memory region, and the beat width. Direction 1 copies buffer bytes out to memory. Direction 0 copies memory into the buffer.

The walker keeps its position in the table between transfers. A table is armed by a rewind pulse, which latches the table base. Each start pulse then moves one buffer, and the next start carries on from where the last one stopped, even in the middle of a region. A transfer ends with a one-cycle completion pulse when the buffer is satisfied. It ends with a one-cycle shortfall pulse when the table runs out first. The table runs out when the final-descriptor flag has been consumed, or when the fetch pointer has moved a full 4 KiB page past the base.

Top module: `sgw_walker`

## Requirements
- R1: A descriptor is fetched as one read request of 8 bytes at the fetch pointer. Its response bytes 0..3 hold the region address and bytes 4..7 hold the size word, both little-endian.
- R2: The region length is the size word masked with 0xFFFE, so bit 0 and bits 16..30 have no effect. A masked value of 0 means 65536 bytes.
- R3: Size word bit 31 marks the final descriptor. Once that region is used up, no further descriptor is fetched.
- R4: A descriptor is fetched only when the current region is empty and buffer bytes are still owed. Each fetch advances the fetch pointer by 8.
- R5: When the region is empty and the fetch pointer is PAGE_BYTES (4096) or more past the table base, the walk stops even though no final flag was seen.
- R6: Each data request moves min(buffer bytes left, region bytes left, BEAT_BYTES) bytes. The region address and length and the buffer index all advance by that amount. Buffer byte idx+k pairs with memory byte addr+k.
- R7: With direction 1, a write request carries buffer bytes read at lbuf_addr_o. With direction 0, a read request is issued, and its response is written into the buffer at lbuf_addr_o for lbuf_len_o bytes.
- R8: done_o pulses for one cycle once the buffer index reaches the requested length. This is tested before the table end, and a length of 0 completes at once with no fetch.
- R9: short_o pulses for one cycle when the walk stops with buffer bytes still owed. Bytes past the moved count are left untouched.
- R10: Region and pointer state persist across starts, so a later start continues inside a partly used region.
- R11: rewind_i while idle loads the fetch pointer and table base from table_base_i and empties the current region.
- R12: After reset, busy_o is low. busy_o is high from the cycle after start_i through the done_o/short_o cycle, and low after it. start_i while busy has no effect.
- R13: After reset no request is issued. A request that is not accepted keeps its valid, address, length and direction until mem_req_ready_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin moving one buffer (idle only) |
| rewind_i | input | 1 | Arm a table at table_base_i (idle only) |
| dir_i | input | 1 | 1: buffer to memory, 0: memory to buffer |
| table_base_i | input | 32 | Table base byte address |
| buf_len_i | input | LEN_W | Buffer length in bytes |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Buffer completed pulse |
| short_o | output | 1 | Table ended early pulse |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_we_o | output | 1 | Request is a write |
| mem_req_addr_o | output | 32 | Request byte address |
| mem_req_len_o | output | CW | Request byte count |
| mem_req_wdata_o | output | 8*BEAT_BYTES | Write bytes, byte k at addr+k |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_rdata_i | input | 8*BEAT_BYTES | Read response bytes |
| lbuf_addr_o | output | LEN_W | Buffer byte index |
| lbuf_rdata_i | input | 8*BEAT_BYTES | Buffer bytes from lbuf_addr_o |
| lbuf_we_o | output | 1 | Buffer write strobe |
| lbuf_wdata_o | output | 8*BEAT_BYTES | Buffer write bytes |
| lbuf_len_o | output | CW | Buffer write byte count |

## Verification
The assertions assume a well-behaved memory side. Exactly one response arrives for each accepted read, and only after that read has been accepted. No response shows up unasked. Rewind and start are also assumed to be pulsed only while the walker is idle, or else ignored. The bench memory model meets these assumptions: it answers each accepted read exactly one cycle later, and it withholds ready every third cycle, so the request-hold rule is exercised. The buffer model answers reads combinationally, and every table it builds stays inside the modelled memory window.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    localparam int ADDR_W       = 32;
    localparam int DESC_BYTES   = 8;
    localparam int REGION_LEN_W = 17;
    localparam int LAST_BIT     = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_FWAIT,
        ST_MOVE,
        ST_MWAIT
    } sgw_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0]       addr;
        logic [REGION_LEN_W-1:0] len;
        logic                    last;
    } sgw_region_t;

    function automatic sgw_region_t decode_desc(input logic [63:0] raw);
        sgw_region_t r;
        logic [15:0] cnt;
        cnt    = {raw[47:33], 1'b0};
        r.addr = raw[31:0];
        r.len  = (cnt == 16'd0) ? 17'h10000 : {1'b0, cnt};
        r.last = raw[32 + LAST_BIT];
        return r;
    endfunction

endpackage

// File: rtl/sgw_chunk.sv
module sgw_chunk #(
    parameter int LEN_W      = 16,
    parameter int BEAT_BYTES = 16,
    parameter int CW         = 5
) (
    input  logic [LEN_W-1:0]                left_i,
    input  logic [sgw_pkg::REGION_LEN_W-1:0] rlen_i,
    output logic [CW-1:0]                   chunk_o
);
    logic [31:0] lw, rw, m;

    always_comb begin
        lw = 32'(left_i);
        rw = 32'(rlen_i);
        m  = 32'(BEAT_BYTES);
        if (lw < m) m = lw;
        if (rw < m) m = rw;
        chunk_o = CW'(m);
    end
endmodule

// File: rtl/sgw_desc_reg.sv
module sgw_desc_reg
    import sgw_pkg::*;
#(
    parameter int PAGE_BYTES = 4096,
    parameter int CW         = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rewind_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              fetch_adv_i,
    input  logic              load_i,
    input  logic [63:0]       desc_i,
    input  logic              adv_i,
    input  logic [CW-1:0]     amt_i,
    output sgw_region_t       region_o,
    output logic [ADDR_W-1:0] fptr_o,
    output logic              exhausted_o
);
    logic [ADDR_W-1:0] base_q, fptr_q;
    sgw_region_t       reg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            fptr_q <= '0;
            reg_q  <= '0;
        end else if (rewind_i) begin
            base_q <= base_i;
            fptr_q <= base_i;
            reg_q  <= '0;
        end else begin
            if (fetch_adv_i) fptr_q <= fptr_q + ADDR_W'(DESC_BYTES);
            if (load_i) begin
                reg_q <= decode_desc(desc_i);
            end else if (adv_i) begin
                reg_q.addr <= reg_q.addr + ADDR_W'(amt_i);
                reg_q.len  <= reg_q.len - REGION_LEN_W'(amt_i);
            end
        end
    end

    assign region_o    = reg_q;
    assign fptr_o      = fptr_q;
    assign exhausted_o = (fptr_q - base_q) >= ADDR_W'(PAGE_BYTES);

    // R4: every fetch steps the pointer by one descriptor
    a_r4_fetch_step: assert property (@(posedge clk) disable iff (rst)
        fetch_adv_i && !rewind_i |=> fptr_q == $past(fptr_q) + ADDR_W'(DESC_BYTES));

    // R5: no fetch is launched once the page limit is reached
    a_r5_page_limit: assert property (@(posedge clk) disable iff (rst)
        fetch_adv_i |-> (fptr_q - base_q) < ADDR_W'(PAGE_BYTES));

    // R2: a freshly loaded region is never empty
    a_r2_len_nonzero: assert property (@(posedge clk) disable iff (rst)
        load_i && !rewind_i |=> reg_q.len != '0);

    // R11: rewind reloads the pointer and empties the region
    a_r11_rewind: assert property (@(posedge clk) disable iff (rst)
        rewind_i |=> fptr_q == $past(base_i) && reg_q.len == '0);
endmodule

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
    import sgw_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CW    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             dir_i,
    input  logic [LEN_W-1:0] buf_len_i,
    input  logic             rzero_i,
    input  logic             rlast_i,
    input  logic             exhausted_i,
    input  logic [CW-1:0]    chunk_i,
    input  logic             req_ready_i,
    input  logic             rsp_valid_i,
    output sgw_state_e       state_o,
    output logic             dir_o,
    output logic [LEN_W-1:0] idx_o,
    output logic [LEN_W-1:0] left_o,
    output logic             fetch_hs_o,
    output logic             load_o,
    output logic             advance_o,
    output logic             done_o,
    output logic             short_o,
    output logic             busy_o
);
    sgw_state_e       state_q, state_d;
    logic [LEN_W-1:0] idx_q, len_q;
    logic             dir_q;

    assign left_o = len_q - idx_q;

    always_comb begin
        state_d    = state_q;
        fetch_hs_o = 1'b0;
        load_o     = 1'b0;
        advance_o  = 1'b0;
        done_o     = 1'b0;
        short_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_CHECK;
            ST_CHECK: begin
                if (left_o == '0) begin
                    done_o  = 1'b1;
                    state_d = ST_IDLE;
                end else if (rzero_i) begin
                    if (rlast_i || exhausted_i) begin
                        short_o = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_FETCH;
                    end
                end else begin
                    state_d = ST_MOVE;
                end
            end
            ST_FETCH: if (req_ready_i) begin
                fetch_hs_o = 1'b1;
                state_d    = ST_FWAIT;
            end
            ST_FWAIT: if (rsp_valid_i) begin
                load_o  = 1'b1;
                state_d = ST_CHECK;
            end
            ST_MOVE: if (req_ready_i) begin
                if (dir_q) begin
                    advance_o = 1'b1;
                    state_d   = ST_CHECK;
                end else begin
                    state_d = ST_MWAIT;
                end
            end
            ST_MWAIT: if (rsp_valid_i) begin
                advance_o = 1'b1;
                state_d   = ST_CHECK;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            len_q   <= '0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                idx_q <= '0;
                len_q <= buf_len_i;
                dir_q <= dir_i;
            end else if (advance_o) begin
                idx_q <= idx_q + LEN_W'(chunk_i);
            end
        end
    end

    assign state_o = state_q;
    assign dir_o   = dir_q;
    assign idx_o   = idx_q;
    assign busy_o  = (state_q != ST_IDLE);

    // R12: status pulses fall inside the busy window and close it
    a_r12_busy_at_pulse: assert property (@(posedge clk) disable iff (rst)
        (done_o || short_o) |-> busy_o);
    a_r12_idle_after: assert property (@(posedge clk) disable iff (rst)
        (done_o || short_o) |=> !busy_o);

    // R8/R9: completion and shortfall never coincide
    a_r8_one_status: assert property (@(posedge clk) disable iff (rst)
        !(done_o && short_o));

    // R6: a data chunk is non-empty and never overruns the buffer
    a_r6_chunk_fits: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_MOVE |-> chunk_i != '0 && LEN_W'(chunk_i) <= left_o);
endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
    import sgw_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int BEAT_BYTES = 16,
    parameter int PAGE_BYTES = 4096,
    localparam int CW        = $clog2(BEAT_BYTES) + 1,
    localparam int DW        = 8 * BEAT_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              rewind_i,
    input  logic              dir_i,
    input  logic [31:0]       table_base_i,
    input  logic [LEN_W-1:0]  buf_len_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              short_o,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic              mem_req_we_o,
    output logic [31:0]       mem_req_addr_o,
    output logic [CW-1:0]     mem_req_len_o,
    output logic [DW-1:0]     mem_req_wdata_o,
    input  logic              mem_rsp_valid_i,
    input  logic [DW-1:0]     mem_rsp_rdata_i,
    output logic [LEN_W-1:0]  lbuf_addr_o,
    input  logic [DW-1:0]     lbuf_rdata_i,
    output logic              lbuf_we_o,
    output logic [DW-1:0]     lbuf_wdata_o,
    output logic [CW-1:0]     lbuf_len_o
);
    sgw_state_e       state;
    sgw_region_t      region;
    logic [ADDR_W-1:0] fptr;
    logic             dir_q, exhausted, fetch_hs, load, advance;
    logic [LEN_W-1:0] idx, left;
    logic [CW-1:0]    chunk;

    sgw_ctrl #(.LEN_W(LEN_W), .CW(CW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .dir_i       (dir_i),
        .buf_len_i   (buf_len_i),
        .rzero_i     (region.len == '0),
        .rlast_i     (region.last),
        .exhausted_i (exhausted),
        .chunk_i     (chunk),
        .req_ready_i (mem_req_ready_i),
        .rsp_valid_i (mem_rsp_valid_i),
        .state_o     (state),
        .dir_o       (dir_q),
        .idx_o       (idx),
        .left_o      (left),
        .fetch_hs_o  (fetch_hs),
        .load_o      (load),
        .advance_o   (advance),
        .done_o      (done_o),
        .short_o     (short_o),
        .busy_o      (busy_o)
    );

    sgw_desc_reg #(.PAGE_BYTES(PAGE_BYTES), .CW(CW)) u_desc (
        .clk         (clk),
        .rst         (rst),
        .rewind_i    (rewind_i && state == ST_IDLE),
        .base_i      (table_base_i),
        .fetch_adv_i (fetch_hs),
        .load_i      (load),
        .desc_i      (mem_rsp_rdata_i[63:0]),
        .adv_i       (advance),
        .amt_i       (chunk),
        .region_o    (region),
        .fptr_o      (fptr),
        .exhausted_o (exhausted)
    );

    sgw_chunk #(.LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES), .CW(CW)) u_chunk (
        .left_i  (left),
        .rlen_i  (region.len),
        .chunk_o (chunk)
    );

    assign mem_req_valid_o = (state == ST_FETCH) || (state == ST_MOVE);
    assign mem_req_we_o    = (state == ST_MOVE) && dir_q;
    assign mem_req_addr_o  = (state == ST_FETCH) ? fptr : region.addr;
    assign mem_req_len_o   = (state == ST_FETCH) ? CW'(DESC_BYTES) : chunk;
    assign mem_req_wdata_o = lbuf_rdata_i;
    assign lbuf_addr_o     = idx;
    assign lbuf_we_o       = (state == ST_MWAIT) && mem_rsp_valid_i;
    assign lbuf_wdata_o    = mem_rsp_rdata_i;
    assign lbuf_len_o      = chunk;

    // R13: an unaccepted request holds its contents
    a_r13_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o
            && $stable(mem_req_addr_o) && $stable(mem_req_len_o) && $stable(mem_req_we_o));

    // R7: buffer writes only happen on the read direction
    a_r7_buf_write_dir: assert property (@(posedge clk) disable iff (rst)
        lbuf_we_o |-> !dir_q && lbuf_len_o != '0);
endmodule

// File: tb/sgw_walker_bench.sv
`timescale 1ns/100ps
module sgw_walker_bench;
    localparam int MEMSZ = 16384;
    localparam int BUFSZ = 4096;
    localparam int REG0  = 'h2000;

    typedef struct packed {
        logic        dir;
        logic [3:0]  nd;
        logic [30:0] raw;
        logic [15:0] blen;
        logic        exp_done;
        logic [15:0] exp_moved;
        logic [9:0]  exp_fetch;
        logic [9:0]  exp_xfer;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 4'd3, 31'h20,    16'd80,  1'b1, 16'd80,  10'd3, 10'd5},
        '{1'b0, 4'd3, 31'h20,    16'd80,  1'b1, 16'd80,  10'd3, 10'd5},
        '{1'b1, 4'd2, 31'h11,    16'd40,  1'b0, 16'd32,  10'd2, 10'd2},
        '{1'b0, 4'd4, 31'h7,     16'd20,  1'b1, 16'd20,  10'd4, 10'd4},
        '{1'b1, 4'd1, 31'h0,     16'd300, 1'b1, 16'd300, 10'd1, 10'd19},
        '{1'b0, 4'd2, 31'h50010, 16'd32,  1'b1, 16'd32,  10'd2, 10'd2},
        '{1'b1, 4'd1, 31'h1,     16'd50,  1'b1, 16'd50,  10'd1, 10'd4},
        '{1'b0, 4'd1, 31'h10,    16'd0,   1'b1, 16'd0,   10'd0, 10'd0}
    };

    logic         clk = 1'b0, rst = 1'b1;
    logic         start_i = 1'b0, rewind_i = 1'b0, dir_i = 1'b0;
    logic [31:0]  table_base_i = '0;
    logic [15:0]  buf_len_i = '0;
    logic         busy_o, done_o, short_o;
    logic         mem_req_valid_o, mem_req_ready_i = 1'b0, mem_req_we_o;
    logic [31:0]  mem_req_addr_o;
    logic [4:0]   mem_req_len_o;
    logic [127:0] mem_req_wdata_o;
    logic         mem_rsp_valid_i = 1'b0;
    logic [127:0] mem_rsp_rdata_i = '0;
    logic [15:0]  lbuf_addr_o;
    logic [127:0] lbuf_rdata_i;
    logic         lbuf_we_o;
    logic [127:0] lbuf_wdata_o;
    logic [4:0]   lbuf_len_o;

    logic [7:0] mem [MEMSZ];
    logic [7:0] lb  [BUFSZ];
    int cyc = 0, fetch_cnt = 0, xfer_cnt = 0, bad_len = 0;
    int checks = 0, fails = 0;
    bit rd_pending = 0;
    int rd_addr = 0;

    always #2.5 clk = ~clk;

    sgw_walker u_sgw_walker (.*);

    always_comb begin
        for (int k = 0; k < 16; k++)
            lbuf_rdata_i[k*8 +: 8] = lb[(int'(lbuf_addr_o) + k) % BUFSZ];
    end

    // memory model: one response a cycle after each accepted read
    always @(negedge clk) begin
        cyc++;
        mem_rsp_valid_i = 1'b0;
        if (rd_pending) begin
            for (int k = 0; k < 16; k++)
                mem_rsp_rdata_i[k*8 +: 8] = mem[(rd_addr + k) % MEMSZ];
            mem_rsp_valid_i = 1'b1;
            rd_pending = 0;
        end
        mem_req_ready_i = (cyc % 3) != 2;
        if (mem_req_valid_o && mem_req_ready_i) begin
            if (mem_req_we_o) begin
                for (int k = 0; k < int'(mem_req_len_o); k++)
                    mem[(int'(mem_req_addr_o) + k) % MEMSZ] = mem_req_wdata_o[k*8 +: 8];
            end else begin
                rd_pending = 1;
                rd_addr = int'(mem_req_addr_o);
            end
            if (!mem_req_we_o && mem_req_len_o == 5'd8 && mem_req_addr_o < REG0) fetch_cnt++;
            else begin
                xfer_cnt++;
                if (mem_req_len_o == 0 || mem_req_len_o > 16) bad_len++;
            end
        end
        #1;
        if (lbuf_we_o)
            for (int k = 0; k < int'(lbuf_len_o); k++)
                lb[(int'(lbuf_addr_o) + k) % BUFSZ] = lbuf_wdata_o[k*8 +: 8];
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int dlen(input logic [30:0] raw);
        int v = int'(raw) & 'hFFFE;
        return (v == 0) ? 65536 : v;
    endfunction

    task automatic put32(input int a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[(a + k) % MEMSZ] = v[k*8 +: 8];
    endtask

    task automatic build(input int base, input int nd, input logic [30:0] raw,
                         input bit last, input int reg0, input int stride);
        for (int k = 0; k < nd; k++) begin
            put32(base + 8*k, 32'(reg0 + k*stride));
            put32(base + 8*k + 4, {last && (k == nd-1), raw});
        end
    endtask

    task automatic rewind(input int base);
        @(negedge clk);
        table_base_i = 32'(base);
        rewind_i = 1'b1;
        @(negedge clk);
        rewind_i = 1'b0;
    endtask

    task automatic pulse_start(input bit d, input int len);
        @(negedge clk);
        dir_i = d;
        buf_len_i = 16'(len);
        start_i = 1'b1;
        fetch_cnt = 0;
        xfer_cnt = 0;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // 1 = done, 2 = short, 0 = timeout; gap counts busy-low cycles before the pulse
    task automatic wait_end(output int status, output int gap);
        status = 0;
        gap = 0;
        for (int t = 0; t < 20000; t++) begin
            if (done_o) begin status = 1; break; end
            if (short_o) begin status = 2; break; end
            if (!busy_o) gap++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        int st, gap, bad;
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int st, gap, bad, L;
        for (int i = 0; i < MEMSZ; i++) mem[i] = 8'h00;
        for (int i = 0; i < BUFSZ; i++) lb[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy_o && !done_o && !short_o, "R12", "reset busy/status", int'(busy_o), 0);
        chk(!mem_req_valid_o, "R13", "reset request", int'(mem_req_valid_o), 0);

        // vector table: R1 R2 R3 R4 R6 R7 R8 R9
        for (int v = 0; v < 8; v++) begin
            vec_t e = VECS[v];
            L = dlen(e.raw);
            build('h100, int'(e.nd), e.raw, 1'b1, REG0, L);
            for (int i = 0; i < 700; i++) begin
                mem[REG0 + i] = e.dir ? 8'hEE : 8'(i*7 + 3 + v);
                lb[i] = e.dir ? 8'(i*13 + 5 + v) : 8'h55;
            end
            rewind('h100);
            pulse_start(e.dir, int'(e.blen));
            wait_end(st, gap);
            chk(st == (e.exp_done ? 1 : 2), "R8/R9", "status", st, e.exp_done ? 1 : 2);
            chk(fetch_cnt == int'(e.exp_fetch), "R1/R4", "descriptor fetches", fetch_cnt, int'(e.exp_fetch));
            chk(xfer_cnt == int'(e.exp_xfer) && bad_len == 0, "R6", "data requests", xfer_cnt, int'(e.exp_xfer));
            bad = 0;
            for (int i = 0; i < int'(e.blen) + 16; i++) begin
                if (e.dir) begin
                    if (mem[REG0 + i] != ((i < int'(e.exp_moved)) ? lb[i] : 8'hEE)) bad++;
                end else begin
                    if (lb[i] != ((i < int'(e.exp_moved)) ? mem[REG0 + i] : 8'h55)) bad++;
                end
            end
            chk(bad == 0, "R7/R2", "data bytes wrong", bad, 0);
            chk(gap == 0 && !busy_o, "R12", "busy window", gap, 0);
        end

        // R5: no final flag, 512 two-byte regions fill exactly one page
        build('h400, 512, 31'h2, 1'b0, REG0, 2);
        for (int i = 0; i < 1100; i++) mem[REG0 + i] = 8'hEE;
        for (int i = 0; i < 2000; i++) lb[i] = 8'(i*3 + 1);
        rewind('h400);
        pulse_start(1'b1, 2000);
        wait_end(st, gap);
        chk(st == 2, "R5", "page fail-safe status", st, 2);
        chk(fetch_cnt == 512, "R5", "page fail-safe fetches", fetch_cnt, 512);
        bad = 0;
        for (int i = 0; i < 1024; i++) if (mem[REG0 + i] != lb[i]) bad++;
        chk(bad == 0 && mem[REG0 + 1024] == 8'hEE, "R5/R9", "fail-safe data", bad, 0);

        // R10 + R12: continue mid-region, ignore start while busy
        build('h100, 1, 31'h10, 1'b1, 'h3000, 16);
        for (int i = 0; i < 64; i++) begin
            mem['h3000 + i] = 8'hEE;
            lb[i] = 8'(i + 'h40);
        end
        rewind('h100);
        pulse_start(1'b1, 10);
        @(negedge clk);
        buf_len_i = 16'd3;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_end(st, gap);
        chk(st == 1, "R12", "start while busy ignored (status)", st, 1);
        chk(mem['h3000 + 9] == lb[9] && mem['h3000 + 10] == 8'hEE, "R12", "start while busy ignored (bytes)",
            int'(mem['h3000 + 9]), int'(lb[9]));
        pulse_start(1'b1, 10);
        wait_end(st, gap);
        chk(st == 2, "R10/R3", "continued region ends short", st, 2);
        chk(fetch_cnt == 0, "R10/R3", "no refetch after final", fetch_cnt, 0);
        bad = 0;
        for (int i = 0; i < 6; i++) if (mem['h3000 + 10 + i] != lb[i]) bad++;
        chk(bad == 0 && mem['h3010] == 8'hEE, "R10", "continued bytes", bad, 0);

        // R11: rewind reads the table from its base again
        for (int i = 0; i < 16; i++) lb[i] = 8'h55;
        rewind('h100);
        pulse_start(1'b0, 4);
        wait_end(st, gap);
        chk(st == 1 && fetch_cnt == 1, "R11", "rewind refetch", fetch_cnt, 1);
        bad = 0;
        for (int i = 0; i < 4; i++) if (lb[i] != mem['h3000 + i]) bad++;
        chk(bad == 0 && lb[4] == 8'h55, "R11", "rewind data", bad, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule